// File: doc/BRIEF.md
# Video Memory Block Copy Engine

This block copies a run of words from one area of a video memory to another while the memory sits behind a single port. A host programs a source pointer, a destination pointer and a control word through a small indexed register write port. It then writes a count to the length register, and that write starts the copy. Each pointer walks upward or downward on its own, as the control word selects. For every word the engine spends one cycle reading the source and the next cycle writing the destination with the data that came back.

During the copy a busy flag is high. When the last word has been written, the engine can raise an interrupt. The interrupt enable is taken from the control word as it stands at the very end, so the host may change it while the copy runs. The interrupt stays up until the host acknowledges it. Two control bits belong to a neighbouring sprite-table transfer unit. This block only stores them and hands them out, and they have no effect on the copy.

Top module: `vram_block_dma`

## Requirements
- R1: While reset is low and after its release, busy, irq, vram_rd and vram_wr are 0, and sat_ctl is 2'b00.
- R2: A register write with reg_sel = 5'h12 while idle starts a copy of N+1 words, where N is reg_wdata[LW-1:0]. busy goes high on the next cycle and stays high for exactly 2*(N+1) cycles.
- R3: Each word takes one cycle with vram_rd=1 at the source address, then the next cycle with vram_wr=1 at the destination address. vram_wdata carries the word returned by the memory, which has one cycle of read latency. vram_rd and vram_wr are never high together.
- R4: Control bit 2 set makes the source pointer decrement after every read; clear makes it increment. Control bit 3 does the same for the destination after every write. Pointers wrap modulo 2^AW. Both directions are captured when the copy starts.
- R5: vram_rd and vram_wr are only asserted while busy is high.
- R6: When the final write completes, irq is set on the next cycle if control bit 1 is set at that moment. A change to control bit 1 during the copy therefore decides the outcome.
- R7: irq stays high until a cycle with irq_ack=1, and it reads 0 on the cycle after. A completion that sets irq wins over an acknowledge in the same cycle.
- R8: While busy, writes to reg_sel 5'h12 (length), 5'h10 (source) and 5'h11 (destination) are ignored, and the running copy continues unchanged.
- R9: A write to reg_sel 5'h0F loads the control word. sat_ctl[1] shows control bit 4 and sat_ctl[0] shows control bit 0. Neither bit changes the copy or irq.
- R10: After a copy, each pointer holds the address one step past the last word it touched. A new length write without reprogramming continues from there.
- R11: Writes with any other reg_sel value change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 5 | Register index (0x0F control, 0x10 source, 0x11 destination, 0x12 length) |
| reg_wdata | input | RW | Register write data |
| irq_ack | input | 1 | Clears the completion interrupt |
| vram_addr | output | AW | Memory address |
| vram_rd | output | 1 | Memory read strobe |
| vram_wr | output | 1 | Memory write strobe |
| vram_wdata | output | DW | Memory write data |
| vram_rdata | input | DW | Memory read data, valid one cycle after vram_rd |
| busy | output | 1 | Copy in progress |
| irq | output | 1 | Completion interrupt |
| sat_ctl | output | 2 | Stored sprite-table bits {repeat, irq enable} |

## Verification
The bench builds the engine with AW=8 and LW=8 and a 256-word memory model. With these values the pointers wrap in both directions within a few words, and the whole memory image can be compared against the bench's shadow copy after every run. Short lengths of 0 to 12 give many copies with overlapping regions and mixed directions. Register pokes timed to fall inside a copy reach the ignored writes and the late change of interrupt enable.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
   typedef enum logic [1:0] {
      XF_IDLE  = 2'd0,
      XF_READ  = 2'd1,
      XF_WRITE = 2'd2
   } xfer_state_e;

   localparam int SEL_W = 5;
   localparam logic [SEL_W-1:0] SEL_CTRL = 5'h0F;
   localparam logic [SEL_W-1:0] SEL_SRC  = 5'h10;
   localparam logic [SEL_W-1:0] SEL_DST  = 5'h11;
   localparam logic [SEL_W-1:0] SEL_LEN  = 5'h12;

   localparam int CTRL_W     = 5;
   localparam int CB_SAT_IRQ = 0;
   localparam int CB_BLK_IRQ = 1;
   localparam int CB_SRC_DEC = 2;   // destination direction is the next bit
   localparam int CB_SAT_RPT = 4;
   localparam int N_PTR      = 2;
endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
   import vdma_pkg::*;
#(
   parameter int AW = 16,
   parameter int LW = 16,
   parameter int RW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [RW-1:0]     wr_data,
   input  logic              busy,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              start,
   output logic [LW-1:0]     len_val,
   output logic [N_PTR-1:0]  ld_ptr,
   output logic [AW-1:0]     ld_val
);
   logic idle_wr;

   assign idle_wr   = wr_en && !busy;
   assign start     = idle_wr && (wr_sel == SEL_LEN);
   assign ld_ptr[0] = idle_wr && (wr_sel == SEL_SRC);
   assign ld_ptr[1] = idle_wr && (wr_sel == SEL_DST);
   assign len_val   = wr_data[LW-1:0];
   assign ld_val    = wr_data[AW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en && (wr_sel == SEL_CTRL)) begin
         ctrl_q <= wr_data[CTRL_W-1:0];
      end
   end
endmodule

// File: rtl/vdma_ptr.sv
module vdma_ptr #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [AW-1:0] ld_val,
   input  logic          start,
   input  logic          dir_in,
   input  logic          step,
   output logic [AW-1:0] ptr,
   output logic          dir_q
);
   localparam logic [AW-1:0] ONE = AW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr   <= '0;
         dir_q <= 1'b0;
      end else begin
         if (start) begin
            dir_q <= dir_in;
         end
         if (ld) begin
            ptr <= ld_val;
         end else if (step) begin
            ptr <= dir_q ? (ptr - ONE) : (ptr + ONE);
         end
      end
   end
endmodule

// File: rtl/vdma_seq.sv
module vdma_seq
   import vdma_pkg::*;
#(
   parameter int LW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [LW-1:0] len_in,
   output xfer_state_e   state,
   output logic          rd_step,
   output logic          wr_step,
   output logic          done
);
   localparam logic [LW-1:0] ONE = LW'(1);

   logic [LW-1:0] remain;
   logic          last;

   assign last    = (remain == '0);
   assign rd_step = (state == XF_READ);
   assign wr_step = (state == XF_WRITE);
   assign done    = wr_step && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= XF_IDLE;
         remain <= '0;
      end else begin
         unique case (state)
            XF_IDLE: begin
               if (start) begin
                  remain <= len_in;
                  state  <= XF_READ;
               end
            end
            XF_READ: begin
               state <= XF_WRITE;
            end
            XF_WRITE: begin
               if (last) begin
                  state <= XF_IDLE;
               end else begin
                  remain <= remain - ONE;
                  state  <= XF_READ;
               end
            end
            default: begin
               state <= XF_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/vram_block_dma.sv
module vram_block_dma
   import vdma_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 16,
   parameter int LW = 16,
   parameter int RW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [SEL_W-1:0] reg_sel,
   input  logic [RW-1:0]    reg_wdata,
   input  logic             irq_ack,
   output logic [AW-1:0]    vram_addr,
   output logic             vram_rd,
   output logic             vram_wr,
   output logic [DW-1:0]    vram_wdata,
   input  logic [DW-1:0]    vram_rdata,
   output logic             busy,
   output logic             irq,
   output logic [1:0]       sat_ctl
);
   if (DW < 1) begin : g_bad_dw
      $error("vram_block_dma: DW must be at least 1");
   end
   if (AW < 1 || AW > RW) begin : g_bad_aw
      $error("vram_block_dma: AW must lie in 1..RW");
   end
   if (LW < 1 || LW > RW) begin : g_bad_lw
      $error("vram_block_dma: LW must lie in 1..RW");
   end
   if (RW < CTRL_W) begin : g_bad_rw
      $error("vram_block_dma: RW too narrow for the control word");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic              start;
   logic [LW-1:0]     len_val;
   logic [N_PTR-1:0]  ld_ptr;
   logic [AW-1:0]     ld_val;
   xfer_state_e       state;
   logic              rd_step;
   logic              wr_step;
   logic              done;
   logic [N_PTR-1:0]  step_v;
   logic [N_PTR-1:0]  dir_v;
   logic [AW-1:0]     ptr_v [N_PTR];

   vdma_regs #(.AW(AW), .LW(LW), .RW(RW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .wr_sel  (reg_sel),
      .wr_data (reg_wdata),
      .busy    (busy),
      .ctrl_q  (ctrl_q),
      .start   (start),
      .len_val (len_val),
      .ld_ptr  (ld_ptr),
      .ld_val  (ld_val)
   );

   vdma_seq #(.LW(LW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .len_in  (len_val),
      .state   (state),
      .rd_step (rd_step),
      .wr_step (wr_step),
      .done    (done)
   );

   assign step_v[0] = rd_step;
   assign step_v[1] = wr_step;

   for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
      vdma_ptr #(.AW(AW)) u_ptr (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld     (ld_ptr[g]),
         .ld_val (ld_val),
         .start  (start),
         .dir_in (ctrl_q[CB_SRC_DEC+g]),
         .step   (step_v[g]),
         .ptr    (ptr_v[g]),
         .dir_q  (dir_v[g])
      );
   end

   assign busy       = (state != XF_IDLE);
   assign vram_rd    = rd_step;
   assign vram_wr    = wr_step;
   assign vram_addr  = wr_step ? ptr_v[1] : ptr_v[0];
   assign vram_wdata = vram_rdata;
   assign sat_ctl    = {ctrl_q[CB_SAT_RPT], ctrl_q[CB_SAT_IRQ]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq <= 1'b0;
      end else if (done && ctrl_q[CB_BLK_IRQ]) begin
         irq <= 1'b1;
      end else if (irq_ack) begin
         irq <= 1'b0;
      end
   end
endmodule

// File: rtl/vdma_chk.sv
module vdma_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          irq,
   input logic          irq_ack,
   input logic          vram_rd,
   input logic          vram_wr,
   input logic [AW-1:0] vram_addr,
   input logic          dir_src,
   input logic          dir_dst
);
   localparam logic [AW-1:0] ONE = AW'(1);

   // R3
   excl_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(vram_rd && vram_wr));

   // R3
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vram_rd |=> vram_wr);

   // R5
   access_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vram_rd || vram_wr) |-> busy);

   // R4
   src_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vram_rd && $past(vram_rd, 2)) |->
         (vram_addr == (dir_src ? ($past(vram_addr, 2) - ONE) : ($past(vram_addr, 2) + ONE))));

   // R4
   dst_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vram_wr && $past(vram_wr, 2)) |->
         (vram_addr == (dir_dst ? ($past(vram_addr, 2) - ONE) : ($past(vram_addr, 2) + ONE))));

   // R6
   irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(vram_wr) && !busy));

   // R7
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack) |=> irq);

   // R7
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !vram_wr) |=> !irq);
endmodule

bind vram_block_dma vdma_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .irq       (irq),
   .irq_ack   (irq_ack),
   .vram_rd   (vram_rd),
   .vram_wr   (vram_wr),
   .vram_addr (vram_addr),
   .dir_src   (dir_v[0]),
   .dir_dst   (dir_v[1])
);

// File: tb/vram_block_dma_tb.sv
module vram_block_dma_tb;
   localparam int DW = 16;
   localparam int AW = 8;
   localparam int LW = 8;
   localparam int RW = 16;
   localparam int DEPTH = 1 << AW;
   localparam logic [4:0] S_CTRL = 5'h0F;
   localparam logic [4:0] S_SRC  = 5'h10;
   localparam logic [4:0] S_DST  = 5'h11;
   localparam logic [4:0] S_LEN  = 5'h12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [4:0]    reg_sel = '0;
   logic [RW-1:0] reg_wdata = '0;
   logic          irq_ack = 1'b0;
   logic [AW-1:0] vram_addr;
   logic          vram_rd;
   logic          vram_wr;
   logic [DW-1:0] vram_wdata;
   logic [DW-1:0] vram_rdata = '0;
   logic          busy;
   logic          irq;
   logic [1:0]    sat_ctl;

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] sh  [DEPTH];
   logic [4:0]    b_ctrl = '0;
   logic [AW-1:0] b_src = '0;
   logic [AW-1:0] b_dst = '0;
   logic          b_irq = 1'b0;
   int            checks = 0;
   int            fails = 0;
   bit            done_flag = 1'b0;

   always #2 clk = ~clk;

   vram_block_dma #(.DW(DW), .AW(AW), .LW(LW), .RW(RW)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_sel    (reg_sel),
      .reg_wdata  (reg_wdata),
      .irq_ack    (irq_ack),
      .vram_addr  (vram_addr),
      .vram_rd    (vram_rd),
      .vram_wr    (vram_wr),
      .vram_wdata (vram_wdata),
      .vram_rdata (vram_rdata),
      .busy       (busy),
      .irq        (irq),
      .sat_ctl    (sat_ctl)
   );

   always @(posedge clk) begin
      if (vram_rd) vram_rdata <= mem[vram_addr];
      if (vram_wr) mem[vram_addr] <= vram_wdata;
   end

   function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input logic dec);
      return dec ? a - 1'b1 : a + 1'b1;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic wreg(input logic [4:0] sel, input logic [RW-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      if (sel == S_CTRL) b_ctrl = d[4:0];
      if (sel == S_SRC)  b_src  = d[AW-1:0];
      if (sel == S_DST)  b_dst  = d[AW-1:0];
   endtask

   task automatic ack_irq();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      b_irq = 1'b0;
      chk(irq === 1'b0, "R7", "irq after ack", irq, 0);
   endtask

   // poke_at < 0 means no register write during the copy
   task automatic xfer(input int n, input int poke_at, input logic [4:0] pidx,
                       input logic [RW-1:0] pdata, input bit ack_last);
      logic sdec;
      logic ddec;
      logic [DW-1:0] v;
      sdec = b_ctrl[2];
      ddec = b_ctrl[3];
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = S_LEN; reg_wdata = RW'(n);
      @(negedge clk);
      reg_wr = 1'b0;
      for (int i = 0; i <= n; i++) begin
         chk(busy === 1'b1, "R5", "busy in read", busy, 1);
         chk(vram_rd === 1'b1 && vram_wr === 1'b0, "R3", "read strobe", {vram_rd, vram_wr}, 2);
         chk(vram_addr === b_src, "R4", "source address", vram_addr, b_src);
         v = sh[b_src];
         if (i == poke_at) begin
            reg_wr = 1'b1; reg_sel = pidx; reg_wdata = pdata;
            if (pidx == S_CTRL) b_ctrl = pdata[4:0];
         end
         @(negedge clk);
         reg_wr = 1'b0;
         chk(vram_wr === 1'b1 && vram_rd === 1'b0, "R3", "write strobe", {vram_rd, vram_wr}, 1);
         chk(vram_addr === b_dst, "R4", "destination address", vram_addr, b_dst);
         chk(vram_wdata === v, "R3", "write data", vram_wdata, v);
         sh[b_dst] = v;
         b_src = nxt(b_src, sdec);
         b_dst = nxt(b_dst, ddec);
         if (i == n && ack_last) irq_ack = 1'b1;
         @(negedge clk);
         irq_ack = 1'b0;
      end
      b_irq = b_ctrl[1] | (b_irq & ~ack_last);
      chk(busy === 1'b0, "R2", "busy after N+1 words", busy, 0);
      chk(irq === b_irq, "R6", "irq after completion", irq, b_irq);
      for (int k = 0; k < DEPTH; k++) begin
         if (mem[k] !== sh[k]) chk(1'b0, "R2", "memory word", mem[k], sh[k]);
      end
      checks++;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [RW-1:0] r;
      void'($urandom(32'h1C0D_E5ED));
      for (int k = 0; k < DEPTH; k++) begin
         mem[k] = DW'($urandom);
         sh[k]  = mem[k];
      end
      repeat (3) @(negedge clk);
      // R1 during reset
      chk({busy, irq, vram_rd, vram_wr, sat_ctl} === 6'b0, "R1", "reset outputs",
          {busy, irq, vram_rd, vram_wr, sat_ctl}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, irq, vram_rd, vram_wr, sat_ctl} === 6'b0, "R1", "after reset",
          {busy, irq, vram_rd, vram_wr, sat_ctl}, 0);

      // R9 sprite-table bits stored, no effect on the copy or irq
      wreg(S_CTRL, 16'h0011);
      chk(sat_ctl === 2'b11, "R9", "sat_ctl", sat_ctl, 3);
      wreg(S_SRC, 16'h0020);
      wreg(S_DST, 16'h0080);
      xfer(2, -1, S_CTRL, 0, 1'b0);
      chk(irq === 1'b0, "R9", "no irq from sprite bit", irq, 0);

      // R2 single word, R4 increment wrap at the top
      wreg(S_CTRL, 16'h0000);
      chk(sat_ctl === 2'b00, "R9", "sat_ctl cleared", sat_ctl, 0);
      wreg(S_SRC, 16'h00FF);
      wreg(S_DST, 16'h0010);
      xfer(0, -1, S_CTRL, 0, 1'b0);
      xfer(1, -1, S_CTRL, 0, 1'b0);   // R10 continues from 0x00

      // R4 decrement wrap at zero on source, destination up
      wreg(S_CTRL, 16'h0004);
      wreg(S_SRC, 16'h0001);
      wreg(S_DST, 16'h0040);
      xfer(3, -1, S_CTRL, 0, 1'b0);
      // R10 continue again, both directions down
      wreg(S_CTRL, 16'h000C);
      xfer(2, -1, S_CTRL, 0, 1'b0);

      // R6 enable raised during the copy
      wreg(S_CTRL, 16'h0000);
      xfer(3, 1, S_CTRL, 16'h0002, 1'b0);
      repeat (5) @(negedge clk);
      chk(irq === 1'b1, "R7", "irq held", irq, 1);
      // R6 enable dropped during the copy: irq stays from before
      xfer(2, 0, S_CTRL, 16'h0000, 1'b0);
      chk(irq === 1'b1, "R7", "irq still held", irq, 1);
      // R7 set wins over ack in the same cycle
      wreg(S_CTRL, 16'h0002);
      xfer(1, -1, S_CTRL, 0, 1'b1);
      chk(irq === 1'b1, "R7", "set beats ack", irq, 1);
      ack_irq();
      // R7 ack with enable off clears at completion
      wreg(S_CTRL, 16'h0000);
      xfer(0, -1, S_CTRL, 0, 1'b0);
      chk(irq === 1'b0, "R6", "no irq when disabled", irq, 0);

      // R8 writes while busy ignored
      xfer(4, 1, S_LEN, 16'h0055, 1'b0);
      xfer(4, 2, S_SRC, 16'h0033, 1'b0);
      xfer(3, 0, S_DST, 16'h0077, 1'b0);

      // R11 unmapped indices change nothing
      wreg(5'h13, 16'hFFFF);
      wreg(5'h00, 16'hFFFF);
      wreg(5'h0E, 16'hFFFF);
      chk(sat_ctl === 2'b00, "R11", "sat_ctl untouched", sat_ctl, 0);
      xfer(1, -1, S_CTRL, 0, 1'b0);
      chk(irq === 1'b0, "R11", "irq untouched", irq, 0);

      // random copies
      for (int t = 0; t < 40; t++) begin
         r = RW'($urandom);
         wreg(S_CTRL, {11'b0, r[4:0]});
         if ($urandom_range(0, 3) != 0) wreg(S_SRC, RW'($urandom));
         if ($urandom_range(0, 3) != 0) wreg(S_DST, RW'($urandom));
         if ($urandom_range(0, 2) == 0)
            xfer($urandom_range(0, 12), 0, S_CTRL, {11'b0, 5'($urandom)}, 1'($urandom));
         else
            xfer($urandom_range(0, 12), -1, S_CTRL, 0, 1'($urandom));
         chk(sat_ctl === {b_ctrl[4], b_ctrl[0]}, "R9", "sat_ctl random", sat_ctl,
             {b_ctrl[4], b_ctrl[0]});
         if (b_irq && $urandom_range(0, 1) == 1) ack_irq();
      end

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule